// File: doc/BRIEF.md
# Barrel Shifter with Carry Out

This block is a single-cycle shift unit for a 32-bit integer datapath. It shifts an operand right arithmetically, right logically, or left logically. The distance is either a 5-bit immediate, zero-extended, or the low five bits of a register value. Alongside the shifted word it produces zero, sign, carry and overflow flags. The carry flag holds the last bit pushed out of the word. Overflow is always cleared.

A request is presented with a one-cycle valid strobe. The result and all four flags are captured in registers and appear on the next cycle with a matching valid output. Between requests the registered result and flags keep their last values. The shifter is built as a logarithmic stage array with one guard bit that catches the outgoing bit. Left shifts reuse the same right-shifting array by mirroring the word on the way in and out.

Top module: `barrel_shift_unit`

## Requirements
- R1: Operation code `op` = 2'b00 selects the arithmetic right shift. Vacated upper positions take copies of operand bit 31.
- R2: `op` = 2'b01 selects the logical right shift. Vacated upper positions are filled with zeros.
- R3: `op` = 2'b10 or 2'b11 (bit 1 set) selects the logical left shift. Vacated lower positions are filled with zeros.
- R4: When `amt_from_reg` is 1, the distance is `reg_amt[4:0]` and `reg_amt[31:5]` has no effect. When it is 0, the distance is `imm_amt`, zero-extended, and `reg_amt` has no effect.
- R5: For a right shift by a distance n of 1 to 31, `flag_cy` equals operand bit n-1.
- R6: For a left shift by a distance n of 1 to 31, `flag_cy` equals operand bit 32-n.
- R7: A distance of 0 returns the operand unchanged and clears `flag_cy`, for every operation.
- R8: `flag_z` is 1 exactly when the registered result is all zeros. `flag_s` equals result bit 31.
- R9: `flag_ov` is 0 after every shift.
- R10: A request strobed with `in_valid` in one cycle produces its result and flags after the next rising edge. `out_valid` is high for exactly that cycle.
- R11: In a cycle without `in_valid`, `out_valid` goes low and `result` and all flags hold their previous values.
- R12: While reset is asserted (`rst_n` low), `out_valid`, `result` and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| op | input | 2 | Shift kind: 00 arithmetic right, 01 logical right, 1x logical left |
| amt_from_reg | input | 1 | 1 takes the distance from `reg_amt`, 0 from `imm_amt` |
| imm_amt | input | 5 | Immediate shift distance |
| reg_amt | input | 32 | Register value; only its low five bits give the distance |
| operand | input | 32 | Word to shift |
| out_valid | output | 1 | Result and flags updated this cycle |
| result | output | 32 | Registered shifted word |
| flag_z | output | 1 | Result is zero |
| flag_s | output | 1 | Result bit 31 |
| flag_cy | output | 1 | Last bit shifted out, 0 for a zero distance |
| flag_ov | output | 1 | Overflow, always cleared by a shift |

## Verification
The bench builds the unit with its default 32-bit data width, which gives a 5-bit distance field. With this width it can sweep every distance from 0 to 31 in all three directions. That sweep reaches both carry extremes: bit 0 leaving on a right shift by 1, and bit 31 leaving on a left shift by 1. Register-sourced distances are sent with junk in the upper 27 bits, and immediate requests with a conflicting register value, to show the unused source has no effect. Idle gaps between strobes, including after reset, show that the registered result and flags hold.

// File: rtl/bshift_pkg.sv
package bshift_pkg;

    // Shift kind encoding; bit 1 set always means a left shift.
    typedef enum logic [1:0] {
        SHOP_SAR     = 2'b00,
        SHOP_SHR     = 2'b01,
        SHOP_SHL     = 2'b10,
        SHOP_SHL_ALT = 2'b11
    } shop_e;

endpackage

// File: rtl/bshift_amt_sel.sv
module bshift_amt_sel #(
    parameter int DATA_W = 32,
    parameter int AMT_W  = 5
) (
    input  logic              from_reg,
    input  logic [AMT_W-1:0]  imm_amt,
    input  logic [DATA_W-1:0] reg_amt,
    output logic [AMT_W-1:0]  amt
);

    // Upper register bits are deliberately discarded.
    logic unused_reg_hi;
    assign unused_reg_hi = ^reg_amt[DATA_W-1:AMT_W];

    always_comb begin
        if (from_reg) amt = reg_amt[AMT_W-1:0];
        else          amt = imm_amt;
    end

endmodule

// File: rtl/bshift_bit_rev.sv
module bshift_bit_rev #(
    parameter int W = 32
) (
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    for (genvar i = 0; i < W; i++) begin : g_rev
        assign dout[i] = din[W-1-i];
    end

endmodule

// File: rtl/bshift_stage_core.sv
module bshift_stage_core #(
    parameter int DATA_W = 32,
    parameter int AMT_W  = 5
) (
    input  logic [DATA_W-1:0] din,
    input  logic              fill,
    input  logic [AMT_W-1:0]  amt,
    output logic [DATA_W-1:0] dout,
    output logic              guard
);

    // One guard bit below the word catches the last bit shifted out.
    localparam int EXT_W = DATA_W + 1;

    logic [AMT_W:0][EXT_W-1:0] stg;

    assign stg[0] = {din, 1'b0};

    for (genvar k = 0; k < AMT_W; k++) begin : g_stage
        localparam int SH = 1 << k;
        assign stg[k+1] = amt[k] ? {{SH{fill}}, stg[k][EXT_W-1:SH]} : stg[k];
    end

    assign dout  = stg[AMT_W][EXT_W-1:1];
    assign guard = stg[AMT_W][0];

endmodule

// File: rtl/barrel_shift_unit.sv
module barrel_shift_unit
    import bshift_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [1:0]        op,
    input  logic              amt_from_reg,
    input  logic [$clog2(DATA_W)-1:0] imm_amt,
    input  logic [DATA_W-1:0] reg_amt,
    input  logic [DATA_W-1:0] operand,
    output logic              out_valid,
    output logic [DATA_W-1:0] result,
    output logic              flag_z,
    output logic              flag_s,
    output logic              flag_cy,
    output logic              flag_ov
);

    localparam int AMT_W = $clog2(DATA_W);
    localparam int MSB   = DATA_W - 1;

    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] res;
        logic              z;
        logic              s;
        logic              cy;
        logic              ov;
    } shst_t;

    shst_t st_d, st_q;

    shop_e             op_e;
    logic              go_left;
    logic [AMT_W-1:0]  sel_amt;
    logic [DATA_W-1:0] rev_in;
    logic [DATA_W-1:0] core_in;
    logic [DATA_W-1:0] core_out;
    logic [DATA_W-1:0] rev_out;
    logic              core_fill;
    logic              core_guard;

    assign op_e    = shop_e'(op);
    assign go_left = op[1];

    bshift_amt_sel #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_amt (
        .from_reg (amt_from_reg),
        .imm_amt  (imm_amt),
        .reg_amt  (reg_amt),
        .amt      (sel_amt)
    );

    bshift_bit_rev #(.W(DATA_W)) u_rev_in (
        .din  (operand),
        .dout (rev_in)
    );

    // Left shifts run through the right-shifting array mirrored.
    assign core_in   = go_left ? rev_in : operand;
    assign core_fill = (op_e == SHOP_SAR) & operand[MSB];

    bshift_stage_core #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_core (
        .din   (core_in),
        .fill  (core_fill),
        .amt   (sel_amt),
        .dout  (core_out),
        .guard (core_guard)
    );

    bshift_bit_rev #(.W(DATA_W)) u_rev_out (
        .din  (core_out),
        .dout (rev_out)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.res = go_left ? rev_out : core_out;
            st_d.z   = (st_d.res == '0);
            st_d.s   = st_d.res[MSB];
            st_d.cy  = core_guard;
            st_d.ov  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign result    = st_q.res;
    assign flag_z    = st_q.z;
    assign flag_s    = st_q.s;
    assign flag_cy   = st_q.cy;
    assign flag_ov   = st_q.ov;

    // R10
    strobe_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(result) && $stable(flag_z)
                       && $stable(flag_s) && $stable(flag_cy) && $stable(flag_ov)));

    // R7
    zero_amount_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && sel_amt == '0) |=> (result == $past(operand) && !flag_cy));

    // R3
    left_vacate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op[1] && sel_amt != '0) |=> !result[0]);

    // R2
    logic_right_vacate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 2'b01 && sel_amt != '0) |=> !result[MSB]);

    // R1
    arith_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 2'b00) |=> (result[MSB] == $past(operand[MSB])));

endmodule

// File: tb/barrel_shift_unit_test.sv
module barrel_shift_unit_test;

    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          in_valid;
    logic [1:0]    op;
    logic          amt_from_reg;
    logic [4:0]    imm_amt;
    logic [DW-1:0] reg_amt;
    logic [DW-1:0] operand;
    logic          out_valid;
    logic [DW-1:0] result;
    logic          flag_z, flag_s, flag_cy, flag_ov;

    always #2 clk = ~clk;   // 250 MHz

    barrel_shift_unit #(.DATA_W(DW)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
        .amt_from_reg(amt_from_reg), .imm_amt(imm_amt), .reg_amt(reg_amt),
        .operand(operand), .out_valid(out_valid), .result(result),
        .flag_z(flag_z), .flag_s(flag_s), .flag_cy(flag_cy), .flag_ov(flag_ov)
    );

    typedef struct {
        logic [1:0]    op;
        logic [DW-1:0] res;
        logic          z, s, cy;
        int            due;
    } item_t;

    item_t q[$];
    item_t last;
    int checks = 0;
    int fails = 0;
    int cyc = 0;
    bit started = 0;
    bit done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic item_t model(input logic [1:0] o, input logic fr,
                                    input logic [4:0] im, input logic [DW-1:0] rv,
                                    input logic [DW-1:0] x);
        item_t e;
        int n;
        n = fr ? int'(rv[4:0]) : int'(im);
        case (o)
            2'b00:   e.res = DW'($signed(x) >>> n);
            2'b01:   e.res = x >> n;
            default: e.res = x << n;
        endcase
        if (n == 0)    e.cy = 1'b0;
        else if (o[1]) e.cy = x[DW-n];
        else           e.cy = x[n-1];
        e.z = (e.res == '0);
        e.s = e.res[DW-1];
        e.op = o;
        e.due = 0;
        return e;
    endfunction

    task automatic drive(input logic [1:0] o, input logic fr, input logic [4:0] im,
                         input logic [DW-1:0] rv, input logic [DW-1:0] x);
        item_t e;
        @(negedge clk);
        op = o; amt_from_reg = fr; imm_amt = im; reg_amt = rv; operand = x;
        in_valid = 1'b1;
        e = model(o, fr, im, rv, x);
        e.due = cyc + 1;
        q.push_back(e);
    endtask

    task automatic idle(input int k);
        for (int i = 0; i < k; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            operand = $urandom;
            reg_amt = $urandom;
        end
    endtask

    // Monitor / scoreboard
    initial begin
        forever begin
            @(negedge clk);
            if (started && !done) begin
                if (out_valid) begin
                    if (q.size() == 0) begin
                        chk(1'b0, "R10", "unexpected out_valid", 1, 0);
                    end else begin
                        item_t e;
                        string rq;
                        e = q.pop_front();
                        chk(e.due == cyc, "R10", "latency", DW'(cyc), DW'(e.due));
                        rq = (e.op == 2'b00) ? "R1" : (e.op == 2'b01) ? "R2" : "R3";
                        chk(result == e.res, rq, "result", result, e.res);
                        chk(flag_cy == e.cy, e.op[1] ? "R6" : "R5", "carry",
                            DW'(flag_cy), DW'(e.cy));
                        chk(flag_z == e.z && flag_s == e.s, "R8", "z,s",
                            DW'({flag_z, flag_s}), DW'({e.z, e.s}));
                        chk(flag_ov == 1'b0, "R9", "overflow", DW'(flag_ov), 0);
                        last = e;
                    end
                end else begin
                    if (q.size() != 0 && q[0].due <= cyc)
                        chk(1'b0, "R10", "missing out_valid", 0, 1);
                    chk(result == last.res && flag_cy == last.cy && flag_z == last.z
                        && flag_s == last.s && flag_ov == 1'b0, "R11", "held state",
                        result, last.res);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL R10 watchdog actual=hung expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; op = 2'b00; amt_from_reg = 1'b0;
        imm_amt = '0; reg_amt = '0; operand = '0;
        last.res = '0; last.z = 1'b0; last.s = 1'b0; last.cy = 1'b0; last.op = 2'b00;
        last.due = 0;
        repeat (3) @(negedge clk);
        // R12: reset state
        chk(out_valid == 1'b0 && result == '0 && flag_z == 1'b0 && flag_s == 1'b0
            && flag_cy == 1'b0 && flag_ov == 1'b0, "R12", "reset outputs",
            result, '0);
        in_valid = 1'b1; operand = 32'hFFFF_FFFF;   // strobe held during reset
        @(negedge clk);
        chk(out_valid == 1'b0 && result == '0, "R12", "reset under strobe", result, '0);
        in_valid = 1'b0;
        rst_n = 1'b1;
        started = 1;
        idle(2);   // R11 holds reset values

        // R7: zero distance for every op
        drive(2'b00, 1'b0, 5'd0, 32'hFFFF_FFFF, 32'h8000_0001);
        drive(2'b01, 1'b0, 5'd0, 32'h1234_5678, 32'hDEAD_BEEF);
        drive(2'b10, 1'b1, 5'd9, 32'hFFFF_FFE0, 32'hC000_0003);
        drive(2'b11, 1'b0, 5'd0, 32'h0, 32'h0);
        idle(1);
        // R5/R6 extremes
        drive(2'b01, 1'b0, 5'd1, 32'h0, 32'h0000_0001);
        drive(2'b10, 1'b0, 5'd1, 32'h0, 32'h8000_0000);
        drive(2'b00, 1'b0, 5'd31, 32'h0, 32'h8000_0000);
        drive(2'b01, 1'b0, 5'd31, 32'h0, 32'h8000_0000);
        drive(2'b10, 1'b0, 5'd31, 32'h0, 32'h0000_0003);
        // R4: register source with junk upper bits, immediate with conflicting reg
        drive(2'b00, 1'b1, 5'd17, 32'hFFFF_FFE3, 32'h8765_4321);
        drive(2'b01, 1'b0, 5'd3, 32'h0000_001F, 32'h8765_4321);
        drive(2'b11, 1'b1, 5'd0, 32'hA5A5_A5C4, 32'h0F0F_0F0F);
        idle(3);
        // Full sweep of distances, all ops, both sources
        for (int n = 0; n < 32; n++) begin
            drive(2'b00, 1'b0, 5'(n), 32'hFFFF_FFFF, 32'hB6DB_6DB6);
            drive(2'b01, 1'b1, 5'd0, {27'h5AA5A5A, 5'(n)}, 32'hB6DB_6DB6);
            drive(2'b10, 1'b0, 5'(n), 32'h0, 32'h6DB6_DB6D);
            if (n % 5 == 0) idle(1);
        end
        // Random traffic with gaps
        for (int i = 0; i < 400; i++) begin
            drive(2'($urandom), 1'($urandom), 5'($urandom), $urandom, $urandom);
            if ($urandom % 4 == 0) idle(1 + $urandom % 3);
        end
        idle(4);
        if (q.size() != 0) chk(1'b0, "R10", "items left", DW'(q.size()), 0);
        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule